// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block compacts the responses of a circuit under built-in self-test into a short signature. Each accepted data beat carries one word, one bit per register stage. Every stage combines its own incoming bit with the bit held by the stage before it. The first stage instead combines its bit with a feedback parity taken over a configurable set of tapped stages. The same starting state and the same beat sequence always leave the same signature in the register.

A seed can be loaded at any time, either by reset or through the seed-load pin. Seed load takes precedence over a data beat in the same cycle. A compare request checks the signature against a golden word supplied from outside and returns a one-cycle verdict: pass or fail, together with a done strobe. Compaction is lossy, so a faulty response stream can still end on the golden signature. A pass therefore means only that the two words are equal.

The data input is a valid/ready stream. A beat is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low while reset or seed load is asserted, and high in every other cycle. A source facing a low `in_ready` keeps its beat and offers it again later. While no beat is taken, the signature holds.

Top module: `misr_sig`

## Requirements
- R1: With `rst_n` low at a clock edge, the signature becomes the parameter `SEED`, and `cmp_done`, `cmp_pass` and `cmp_fail` become 0.
- R2: With `rst_n` high and `seed_load` high at an edge, the signature becomes `seed_value`, whatever `in_valid` is. `in_ready` equals `rst_n AND NOT seed_load`.
- R3: On an accepted beat, the next value of bit 0 is the feedback parity XOR `in_data[0]`, where the feedback parity is the XOR of all signature bits whose position is set in `TAP_MASK`. The next value of each bit i>0 is old bit i-1 XOR `in_data[i]`.
- R4: With `USE_XNOR`=1, every bit's next value on an accepted beat is the inverse of the R3 result.
- R5: In a cycle with no accepted beat and no seed load, the signature keeps its value.
- R6: A `cmp_req` sampled high at edge t makes `cmp_done` high for exactly the cycle after t. The compare uses the signature as it was before edge t, even if a beat is accepted at t.
- R7: When `cmp_done` is high, exactly one of `cmp_pass` (signature equal to `golden`) and `cmp_fail` (not equal) is high. Both are low when `cmp_done` is low.
- R8: Starting from the same seed, the same beat sequence gives the same final signature.
- R9: If two response streams differ only by an error pair whose effects cancel in the register, the compare still reports pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low, loads `SEED` |
| seed_load | input | 1 | Load `seed_value` into the signature |
| seed_value | input | WIDTH | Seed word |
| in_valid | input | 1 | Data beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_data | input | WIDTH | Response word, one bit per stage |
| cmp_req | input | 1 | Request a compare against `golden` |
| golden | input | WIDTH | Expected signature |
| sig_out | output | WIDTH | Current signature |
| cmp_done | output | 1 | Compare verdict strobe |
| cmp_pass | output | 1 | Signature matched golden |
| cmp_fail | output | 1 | Signature differed from golden |

## Verification
The bench builds two instances side by side. The first uses the default 4-bit width, taps 0xC and plain XOR stages. Its small state space makes it easy to drive deliberate cancelling error pairs and to follow every bit. The second is 16 bits wide, uses taps 0xD008 and the XNOR stage option. It exercises the inverted fold and a feedback set spread across the whole word. Both instances get the same beats, seeds and compare requests, so a compare that passes on one and a stall that holds on the other are seen in the same cycles.

// File: rtl/misr_pkg.sv
package misr_pkg;

  typedef enum logic [1:0] {
    CMP_NONE     = 2'd0,
    CMP_MATCH    = 2'd1,
    CMP_MISMATCH = 2'd2
  } cmp_res_e;

  // Combine an upstream bit with a data bit; optionally inverted.
  function automatic logic fold_bit(input logic upstream, input logic din, input bit invert);
    logic x;
    x = upstream ^ din;
    return invert ? ~x : x;
  endfunction

endpackage

// File: rtl/misr_feedback.sv
module misr_feedback #(
  parameter int              WIDTH    = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'hC
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH-1:0] tapped;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign tapped[i] = state[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign fb = ^tapped;
endmodule

// File: rtl/misr_stage.sv
module misr_stage
  import misr_pkg::*;
#(
  parameter logic RST_VAL = 1'b0,
  parameter bit   INVERT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic seed_bit,
  input  logic capture,
  input  logic upstream,
  input  logic din,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= RST_VAL;
    else if (load)    q <= seed_bit;
    else if (capture) q <= fold_bit(upstream, din, INVERT);
  end
endmodule

// File: rtl/misr_compare.sv
module misr_compare
  import misr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDTH-1:0] sig,
  input  logic [WIDTH-1:0] golden,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  cmp_res_e res_q;
  logic     done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= CMP_NONE;
      done_q <= 1'b0;
    end else begin
      done_q <= req;
      if (!req)                res_q <= CMP_NONE;
      else if (sig == golden)  res_q <= CMP_MATCH;
      else                     res_q <= CMP_MISMATCH;
    end
  end

  assign done = done_q;
  assign pass = (res_q == CMP_MATCH);
  assign fail = (res_q == CMP_MISMATCH);
endmodule

// File: rtl/misr_sig.sv
module misr_sig
  import misr_pkg::*;
#(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'hC,
  parameter logic [WIDTH-1:0] SEED     = 4'h1,
  parameter bit               USE_XNOR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             cmp_req,
  input  logic [WIDTH-1:0] golden,
  output logic [WIDTH-1:0] sig_out,
  output logic             cmp_done,
  output logic             cmp_pass,
  output logic             cmp_fail
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] sig;
  logic [WIDTH-1:0] upstream;
  logic             fb;
  logic             capture;

  assign in_ready = rst_n & ~seed_load;
  assign capture  = in_valid & in_ready;

  misr_feedback #(
    .WIDTH   (WIDTH),
    .TAP_MASK(TAP_MASK)
  ) u_feedback (
    .state(sig),
    .fb   (fb)
  );

  // Stage 0 sees the feedback parity; stage i sees stage i-1.
  assign upstream = {sig[LAST-1:0], fb};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    misr_stage #(
      .RST_VAL(SEED[i]),
      .INVERT (USE_XNOR)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (seed_load),
      .seed_bit(seed_value[i]),
      .capture (capture),
      .upstream(upstream[i]),
      .din     (in_data[i]),
      .q       (sig[i])
    );
  end

  misr_compare #(
    .WIDTH(WIDTH)
  ) u_compare (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cmp_req),
    .sig   (sig),
    .golden(golden),
    .done  (cmp_done),
    .pass  (cmp_pass),
    .fail  (cmp_fail)
  );

  assign sig_out = sig;
endmodule

// File: rtl/misr_sig_chk.sv
module misr_sig_chk #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] SEED  = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_value,
  input logic             in_valid,
  input logic             in_ready,
  input logic             cmp_req,
  input logic [WIDTH-1:0] golden,
  input logic [WIDTH-1:0] sig_out,
  input logic             cmp_done,
  input logic             cmp_pass,
  input logic             cmp_fail
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (sig_out == SEED) && !cmp_done && !cmp_pass && !cmp_fail);

  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> sig_out == $past(seed_value));

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |-> !in_ready);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !(in_valid && in_ready)) |=> $stable(sig_out));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> cmp_done);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> !cmp_done);

  p_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmp_pass, cmp_fail}) && (cmp_done == (cmp_pass || cmp_fail)));

  p_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && (sig_out == golden)) |=> cmp_pass);
endmodule

bind misr_sig misr_sig_chk #(
  .WIDTH(WIDTH),
  .SEED (SEED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seed_load (seed_load),
  .seed_value(seed_value),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .cmp_req   (cmp_req),
  .golden    (golden),
  .sig_out   (sig_out),
  .cmp_done  (cmp_done),
  .cmp_pass  (cmp_pass),
  .cmp_fail  (cmp_fail)
);

// File: tb/misr_sig_bench.sv
module misr_sig_bench;
  localparam logic [3:0]  N_MASK = 4'hC;
  localparam logic [3:0]  N_SEED = 4'h1;
  localparam logic [15:0] W_MASK = 16'hD008;
  localparam logic [15:0] W_SEED = 16'h5A3C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, seed_load = 1'b0, in_valid = 1'b0, cmp_req = 1'b0;
  logic [15:0] data = '0, seed_v = '0, gold_n = '0, gold_w = '0;
  logic [15:0] corr_n = '0, corr_w = '0;
  logic [3:0]  n_data;
  logic [15:0] w_data;
  assign n_data = data[3:0] ^ corr_n[3:0];
  assign w_data = data ^ corr_w;

  logic        n_ready, n_done, n_pass, n_fail;
  logic [3:0]  n_sig;
  logic        w_ready, w_done, w_pass, w_fail;
  logic [15:0] w_sig;

  misr_sig u_misr_sig (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_v[3:0]),
    .in_valid(in_valid), .in_ready(n_ready), .in_data(n_data),
    .cmp_req(cmp_req), .golden(gold_n[3:0]), .sig_out(n_sig),
    .cmp_done(n_done), .cmp_pass(n_pass), .cmp_fail(n_fail)
  );

  misr_sig #(
    .WIDTH(16), .TAP_MASK(W_MASK), .SEED(W_SEED), .USE_XNOR(1'b1)
  ) u_misr_sig_w16 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_v),
    .in_valid(in_valid), .in_ready(w_ready), .in_data(w_data),
    .cmp_req(cmp_req), .golden(gold_w), .sig_out(w_sig),
    .cmp_done(w_done), .cmp_pass(w_pass), .cmp_fail(w_fail)
  );

  int vectors = 0;
  int miscompares = 0;

  // Behavioural next-signature: shift up, feedback parity into bit 0, fold data.
  function automatic logic [15:0] model_step(input logic [15:0] s, input logic [15:0] d,
                                             input logic [15:0] m, input int w, input bit xn);
    logic [15:0] all, n;
    int          ones;
    all  = (w >= 16) ? 16'hFFFF : 16'((32'd1 << w) - 1);
    ones = $countones(s & m & all);
    n    = ((s << 1) | 16'(ones % 2)) ^ d;
    if (xn) n = ~n;
    return n & all;
  endfunction

  logic [15:0] m_sig_n, m_sig_w;
  bit m_done, m_pass_n, m_fail_n, m_pass_w, m_fail_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sig_n = 16'(N_SEED); m_sig_w = W_SEED;
      m_done = 0; m_pass_n = 0; m_fail_n = 0; m_pass_w = 0; m_fail_w = 0;
    end else begin
      m_done   = cmp_req;
      m_pass_n = cmp_req && (m_sig_n[3:0] == gold_n[3:0]);
      m_fail_n = cmp_req && (m_sig_n[3:0] != gold_n[3:0]);
      m_pass_w = cmp_req && (m_sig_w == gold_w);
      m_fail_w = cmp_req && (m_sig_w != gold_w);
      if (seed_load) begin
        m_sig_n = {12'h0, seed_v[3:0]};
        m_sig_w = seed_v;
      end else if (in_valid) begin
        m_sig_n = model_step(m_sig_n, {12'h0, n_data}, 16'(N_MASK), 4, 1'b0);
        m_sig_w = model_step(m_sig_w, w_data, W_MASK, 16, 1'b1);
      end
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare both instances against the model (R3 for the XOR fold, R4 for XNOR).
  task automatic check_all();
    bit rdy;
    rdy = rst_n && !seed_load;
    check("R3", "narrow signature", {12'h0, n_sig}, m_sig_n);
    check("R4", "wide signature", w_sig, m_sig_w);
    check("R2", "narrow ready", {15'h0, n_ready}, {15'h0, rdy});
    check("R2", "wide ready", {15'h0, w_ready}, {15'h0, rdy});
    check("R6", "done", {14'h0, n_done, w_done}, {14'h0, m_done, m_done});
    check("R7", "narrow verdict", {14'h0, n_pass, n_fail}, {14'h0, m_pass_n, m_fail_n});
    check("R7", "wide verdict", {14'h0, w_pass, w_fail}, {14'h0, m_pass_w, m_fail_w});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [15:0] pat(input int k);
    return 16'((k * 16'h3A7D) ^ (k << 5) ^ 16'h0C41);
  endfunction

  task automatic load_seed(input logic [15:0] s);
    seed_v = s; seed_load = 1'b1; in_valid = 1'b1; data = 16'hFFFF;
    tick();
    check("R2", "seed narrow", {12'h0, n_sig}, {12'h0, s[3:0]});
    check("R2", "seed wide", w_sig, s);
    seed_load = 1'b0; in_valid = 1'b0;
  endtask

  task automatic feed(input int count, input int err_at);
    for (int k = 0; k < count; k++) begin
      data = pat(k); in_valid = 1'b1;
      corr_n = '0; corr_w = '0;
      if (err_at >= 0 && k == err_at) begin
        corr_n = 16'h0001; corr_w = 16'h0001;
      end
      if (err_at >= 0 && k == err_at + 1) begin
        // Diff 1 one beat earlier evolves linearly; this cancels it (R9).
        corr_n = model_step(16'h0001, 16'h0, 16'(N_MASK), 4, 1'b0);
        corr_w = model_step(16'h0001, 16'h0, W_MASK, 16, 1'b0);
      end
      tick();
    end
    in_valid = 1'b0; corr_n = '0; corr_w = '0;
  endtask

  logic [15:0] g_n, g_w, h_n, h_w;

  initial begin
    // R1: reset state
    tick(); tick();
    check("R1", "reset narrow", {12'h0, n_sig}, 16'(N_SEED));
    check("R1", "reset wide", w_sig, W_SEED);
    check("R1", "reset verdict", {13'h0, n_done, n_pass, n_fail}, 16'h0);
    rst_n = 1'b1;

    // R3/R4: stream of beats, with gaps
    for (int k = 0; k < 24; k++) begin
      data = pat(k + 7); in_valid = (k % 5) != 3;
      tick();
    end
    in_valid = 1'b0;

    // R5: hold while idle, even with data changing
    h_n = {12'h0, n_sig}; h_w = w_sig;
    for (int k = 0; k < 4; k++) begin
      data = pat(k + 100);
      tick();
    end
    check("R5", "hold narrow", {12'h0, n_sig}, h_n);
    check("R5", "hold wide", w_sig, h_w);

    // R6/R7: matching compare while a beat is also accepted
    gold_n = {12'h0, n_sig}; gold_w = w_sig; cmp_req = 1'b1; in_valid = 1'b1; data = 16'h9E37;
    tick();
    cmp_req = 1'b0; in_valid = 1'b0;
    check("R6", "match uses pre-beat signature", {14'h0, n_pass, w_pass}, 16'h3);
    tick();
    check("R6", "done one cycle", {14'h0, n_done, w_done}, 16'h0);

    // R7: mismatching compare
    gold_n = {12'h0, n_sig ^ 4'h8}; gold_w = w_sig ^ 16'h0100; cmp_req = 1'b1;
    tick();
    cmp_req = 1'b0;
    check("R7", "mismatch fails", {14'h0, n_fail, w_fail}, 16'h3);

    // R2: seed load beats an offered beat
    load_seed(16'hB6C3);

    // R8: two clean runs from one seed agree
    feed(10, -1);
    g_n = {12'h0, n_sig}; g_w = w_sig;
    load_seed(16'hB6C3);
    feed(10, -1);
    check("R8", "repeat narrow", {12'h0, n_sig}, g_n);
    check("R8", "repeat wide", w_sig, g_w);

    // R9: cancelling error pair aliases to the golden word
    load_seed(16'hB6C3);
    feed(10, 4);
    gold_n = g_n; gold_w = g_w; cmp_req = 1'b1;
    tick();
    cmp_req = 1'b0;
    check("R9", "aliased pass", {14'h0, n_pass, w_pass}, 16'h3);

    // R1: reset in mid-stream returns to the parameter seed
    in_valid = 1'b1; data = 16'h1234; rst_n = 1'b0;
    tick();
    check("R1", "re-reset narrow", {12'h0, n_sig}, 16'(N_SEED));
    check("R1", "re-reset wide", w_sig, W_SEED);
    rst_n = 1'b1; in_valid = 1'b0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule